// File: doc/BRIEF.md
# Add-Order Market-Data Filter

This block sits between a byte-serial market-data feed and an order-book engine. The feed is a continuous stream of binary messages. Each message starts with a two-byte big-endian length, and that many payload bytes follow it. The block tracks the framing, reads the message type in the first payload byte and passes through only add-order messages whose instrument symbol equals an 8-byte value held on a configuration input. Every other message is consumed in full and produces nothing.

For each message it keeps, the block gathers these fields into one fixed-width command: event time, order reference, side, quantity and price. It then offers that command downstream over a valid/ready handshake. The output holds one command at a time. While that command waits for the consumer, the byte input holds its ready low, so no feed data is lost.

Top module: `mdfeed_add_filter`

## Requirements
- R1: After a synchronous reset, `cmd_valid` is 0, `in_ready` is 1 and the next accepted byte is taken as the high byte of a length header.
- R2: A message is a 2-byte big-endian length L followed by L payload bytes. A message with L = 0 consists of its header only, and the byte after it is the next header.
- R3: A message is a candidate only when payload byte 0 equals 0x41 ('A'). Any other type is skipped for its whole length and yields no command.
- R4: Payload bytes 18..25 are compared with `sym_cfg`, with byte 18 matched against `sym_cfg[63:56]` and byte 25 against `sym_cfg[7:0]`. Any difference drops the message.
- R5: All fields of an accepted message are big-endian. Bytes 1..4 appear on `cmd_ts`, bytes 5..12 on `cmd_ref`, bytes 14..17 on `cmd_qty` and bytes 26..29 on `cmd_price`.
- R6: Payload byte 13 gives the side. 0x42 ('B') sets `cmd_buy` to 1 and 0x53 ('S') sets it to 0. Any other value drops the message.
- R7: An add message with L < 30 is dropped. An add message with L >= 30 is accepted when its other checks pass, and its bytes beyond 29 are skipped.
- R8: `cmd_valid` rises in the cycle after the clock edge that accepts the last payload byte of an accepted message. A dropped message never raises it.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, `in_ready` is 0, and the command fields and `cmd_valid` stay unchanged.
- R10: Each accepted message produces exactly one command handshake, and commands leave in message order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_cfg | input | 64 | Instrument symbol to keep, first character in bits 63:56 |
| in_valid | input | 1 | Feed byte present |
| in_data | input | 8 | Feed byte |
| in_ready | output | 1 | Block can take a feed byte |
| cmd_valid | output | 1 | Add-order command present |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_ts | output | 32 | Event time in nanoseconds |
| cmd_ref | output | 64 | Order reference |
| cmd_buy | output | 1 | 1 for buy, 0 for sell |
| cmd_qty | output | 32 | Share quantity |
| cmd_price | output | 32 | Price, four implied decimals |

## Verification
The only result with a latency is the command. It is due one cycle after the edge that accepts a message's final payload byte. The bench drives inputs just after a rising edge and checks `cmd_valid` at the falling edge that follows that acceptance, so both kept and dropped messages are judged in that exact cycle. Commands are compared when they are handshaken, against an in-order list the bench builds from the message bytes. Under back-pressure, `in_ready` and the held fields are checked at each falling edge of the stall. After the stall, a further message is sent to confirm that the framing stayed aligned.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
  localparam int LEN_W = 16;
  typedef logic [LEN_W-1:0] ofs_t;

  localparam logic [7:0] MSG_ADD  = 8'h41;
  localparam logic [7:0] SIDE_BUY = 8'h42;
  localparam logic [7:0] SIDE_SEL = 8'h53;

  localparam int SYM_BYTES = 8;
  localparam ofs_t OFS_TS   = 1;
  localparam ofs_t OFS_REF  = 5;
  localparam ofs_t OFS_SIDE = 13;
  localparam ofs_t OFS_QTY  = 14;
  localparam ofs_t OFS_SYM  = 18;
  localparam ofs_t OFS_PX   = 26;
  localparam ofs_t ADD_LAST = 29;

  typedef struct packed {
    logic [31:0] ts;
    logic [63:0] oref;
    logic        buy;
    logic [31:0] qty;
    logic [31:0] price;
  } add_cmd_t;
endpackage

// File: rtl/mdf_framer.sv
module mdf_framer
  import mdf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_fire,
  input  logic [7:0] byte_data,
  output logic       pay_fire,
  output ofs_t       pay_ofs,
  output logic       pay_last
);
  typedef enum logic [1:0] {HDR_HI, HDR_LO, PAY} fr_state_t;

  fr_state_t  state_q;
  logic [7:0] len_hi_q;
  ofs_t       len_q;
  ofs_t       ofs_q;
  ofs_t       len_now;

  assign len_now  = {len_hi_q, byte_data};
  assign pay_fire = byte_fire && (state_q == PAY);
  assign pay_ofs  = ofs_q;
  assign pay_last = (ofs_q == len_q - ofs_t'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= HDR_HI;
      len_hi_q <= '0;
      len_q    <= '0;
      ofs_q    <= '0;
    end else if (byte_fire) begin
      case (state_q)
        HDR_HI: begin
          len_hi_q <= byte_data;
          state_q  <= HDR_LO;
        end
        HDR_LO: begin
          len_q   <= len_now;
          ofs_q   <= '0;
          state_q <= (len_now == '0) ? HDR_HI : PAY;
        end
        default: begin
          ofs_q <= ofs_q + ofs_t'(1);
          if (pay_last) state_q <= HDR_HI;
        end
      endcase
    end
  end

  assert_ofs_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == PAY) |-> (ofs_q < len_q));
endmodule

// File: rtl/mdf_capture.sv
module mdf_capture
  import mdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        pay_fire,
  input  ofs_t        pay_ofs,
  input  logic        pay_last,
  input  logic [7:0]  data,
  input  logic [63:0] sym_cfg,
  output logic        msg_keep,
  output add_cmd_t    cmd_next
);
  logic [7:0] sym_b [SYM_BYTES];
  genvar g;
  generate
    for (g = 0; g < SYM_BYTES; g++) begin : g_sym
      assign sym_b[g] = sym_cfg[63-8*g -: 8];
    end
  endgenerate

  logic     is_add_q, side_ok_q, sym_ok_q;
  logic     is_add_n, side_ok_n, sym_ok_n;
  add_cmd_t f_q, f_n;
  logic [2:0] sym_idx;

  assign sym_idx = pay_ofs[2:0] - 3'd2;

  always_comb begin
    is_add_n  = is_add_q;
    side_ok_n = side_ok_q;
    sym_ok_n  = sym_ok_q;
    f_n       = f_q;
    if (pay_fire) begin
      if (pay_ofs == '0) begin
        is_add_n = (data == MSG_ADD);
        sym_ok_n = 1'b1;
      end else if (pay_ofs < OFS_REF) begin
        f_n.ts = {f_q.ts[23:0], data};
      end else if (pay_ofs < OFS_SIDE) begin
        f_n.oref = {f_q.oref[55:0], data};
      end else if (pay_ofs == OFS_SIDE) begin
        f_n.buy   = (data == SIDE_BUY);
        side_ok_n = (data == SIDE_BUY) || (data == SIDE_SEL);
      end else if (pay_ofs < OFS_SYM) begin
        f_n.qty = {f_q.qty[23:0], data};
      end else if (pay_ofs < OFS_PX) begin
        sym_ok_n = sym_ok_q && (data == sym_b[sym_idx]);
      end else if (pay_ofs <= ADD_LAST) begin
        f_n.price = {f_q.price[23:0], data};
      end
    end
  end

  assign msg_keep = pay_fire && pay_last && is_add_n && side_ok_n && sym_ok_n
                    && (pay_ofs >= ADD_LAST);
  assign cmd_next = f_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_add_q  <= 1'b0;
      side_ok_q <= 1'b0;
      sym_ok_q  <= 1'b0;
    end else begin
      is_add_q  <= is_add_n;
      side_ok_q <= side_ok_n;
      sym_ok_q  <= sym_ok_n;
    end
    f_q <= f_n;
  end

  assert_keep_needs_type_R3: assert property (@(posedge clk) disable iff (rst)
    (msg_keep && pay_ofs != '0) |-> is_add_q);
endmodule

// File: rtl/mdf_cmd_out.sv
module mdf_cmd_out
  import mdf_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  add_cmd_t cmd_in,
  input  logic     out_ready,
  output logic     out_valid,
  output add_cmd_t cmd_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
    if (load) cmd_out <= cmd_in;
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(cmd_out)));

  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> !out_valid);
endmodule

// File: rtl/mdfeed_add_filter.sv
module mdfeed_add_filter
  import mdf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [63:0] sym_cfg,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [31:0] cmd_ts,
  output logic [63:0] cmd_ref,
  output logic        cmd_buy,
  output logic [31:0] cmd_qty,
  output logic [31:0] cmd_price
);
  logic     byte_fire, pay_fire, pay_last, keep;
  ofs_t     pay_ofs;
  add_cmd_t nxt, held;

  assign in_ready  = !cmd_valid;
  assign byte_fire = in_valid && in_ready;

  mdf_framer i_framer (
    .clk(clk), .rst(rst), .byte_fire(byte_fire), .byte_data(in_data),
    .pay_fire(pay_fire), .pay_ofs(pay_ofs), .pay_last(pay_last)
  );

  mdf_capture i_capture (
    .clk(clk), .rst(rst), .pay_fire(pay_fire), .pay_ofs(pay_ofs),
    .pay_last(pay_last), .data(in_data), .sym_cfg(sym_cfg),
    .msg_keep(keep), .cmd_next(nxt)
  );

  mdf_cmd_out i_out (
    .clk(clk), .rst(rst), .load(keep), .cmd_in(nxt),
    .out_ready(cmd_ready), .out_valid(cmd_valid), .cmd_out(held)
  );

  assign cmd_ts    = held.ts;
  assign cmd_ref   = held.oref;
  assign cmd_buy   = held.buy;
  assign cmd_qty   = held.qty;
  assign cmd_price = held.price;

  assert_cmd_after_byte_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(in_valid && in_ready));

  assert_single_handshake_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_valid);
endmodule

// File: tb/test_mdfeed_add_filter.sv
module test_mdfeed_add_filter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [63:0] sym_cfg = 64'h4142_4344_2020_2020;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, cmd_valid, cmd_buy;
  logic cmd_ready = 1'b1;
  logic [31:0] cmd_ts, cmd_qty, cmd_price;
  logic [63:0] cmd_ref;

  int total = 0, bad = 0, pushed = 0, got = 0;
  logic [7:0] mbuf [64];
  logic [160:0] exp_q [$];

  always #2 clk = ~clk;

  mdfeed_add_filter i_mdfeed_add_filter (
    .clk(clk), .rst(rst), .sym_cfg(sym_cfg), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_ts(cmd_ts), .cmd_ref(cmd_ref),
    .cmd_buy(cmd_buy), .cmd_qty(cmd_qty), .cmd_price(cmd_price)
  );

  task automatic chk(input bit ok, input string req, input logic [160:0] act,
                     input logic [160:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5 R10: every handshake is compared in order against the bench list
  always @(negedge clk) begin
    if (!rst && cmd_valid && cmd_ready) begin
      got++;
      if (exp_q.size() == 0) begin
        chk(0, "R10 unexpected command", {cmd_ts, cmd_ref, cmd_buy, cmd_qty, cmd_price}, '0);
      end else begin
        logic [160:0] e;
        e = exp_q.pop_front();
        chk({cmd_ts, cmd_ref, cmd_buy, cmd_qty, cmd_price} == e, "R5 fields",
            {cmd_ts, cmd_ref, cmd_buy, cmd_qty, cmd_price}, e);
      end
    end
  end

  task automatic put_byte(input logic [7:0] b);
    bit acc;
    in_valid = 1'b1;
    in_data  = b;
    do begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
    end while (!acc);
  endtask

  task automatic build(input int k, input logic [7:0] typ, input logic [7:0] side);
    logic [31:0] ts, qty, px;
    logic [63:0] oref;
    ts   = 32'h1000_0000 + 32'(k) * 32'h0001_0203;
    oref = {32'(k) * 32'h9E37_79B9, 32'hC0DE_0000 ^ 32'(k)};
    qty  = 32'(k) * 7 + 1;
    px   = 32'(k) * 12345 + 100;
    for (int i = 0; i < 64; i++) mbuf[i] = 8'hE0 + 8'(i);
    mbuf[0]  = typ;
    mbuf[13] = side;
    for (int i = 0; i < 4; i++) begin
      mbuf[1+i]  = ts[31-8*i -: 8];
      mbuf[14+i] = qty[31-8*i -: 8];
      mbuf[26+i] = px[31-8*i -: 8];
    end
    for (int i = 0; i < 8; i++) begin
      mbuf[5+i]  = oref[63-8*i -: 8];
      mbuf[18+i] = sym_cfg[63-8*i -: 8];
    end
  endtask

  // expected result computed from the message bytes per R3..R7
  task automatic send_msg(input int len, input string req);
    bit acc;
    logic [15:0] l16;
    logic [160:0] e;
    l16 = 16'(len);
    acc = (len >= 30) && (mbuf[0] == 8'h41) &&
          ((mbuf[13] == 8'h42) || (mbuf[13] == 8'h53));
    for (int i = 0; i < 8; i++)
      if (len >= 30 && mbuf[18+i] != sym_cfg[63-8*i -: 8]) acc = 0;
    if (acc) begin
      e = {mbuf[1], mbuf[2], mbuf[3], mbuf[4],
           mbuf[5], mbuf[6], mbuf[7], mbuf[8], mbuf[9], mbuf[10], mbuf[11], mbuf[12],
           (mbuf[13] == 8'h42),
           mbuf[14], mbuf[15], mbuf[16], mbuf[17],
           mbuf[26], mbuf[27], mbuf[28], mbuf[29]};
      exp_q.push_back(e);
      pushed++;
    end
    put_byte(l16[15:8]);
    put_byte(l16[7:0]);
    for (int i = 0; i < len; i++) put_byte(mbuf[i]);
    in_valid = 1'b0;
    @(negedge clk);
    // R8: command present exactly in the cycle after the last byte edge
    chk(cmd_valid == acc, req, 161'(cmd_valid), 161'(acc));
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid == 0, "R1 cmd_valid after reset", 161'(cmd_valid), 0);
    chk(in_ready == 1, "R1 in_ready after reset", 161'(in_ready), 1);
    @(posedge clk);
    #1;

    // R5 R6: basic buy and sell
    build(1, 8'h41, 8'h42); send_msg(30, "R8 buy accepted");
    build(2, 8'h41, 8'h53); send_msg(30, "R8 sell accepted");

    // R3: every type byte
    for (int t = 0; t < 256; t++) begin
      build(t + 10, 8'(t), 8'h42);
      send_msg(30, "R3 type sweep");
    end

    // R6: every side byte
    for (int s = 0; s < 256; s++) begin
      build(s + 300, 8'h41, 8'(s));
      send_msg(30, "R6 side sweep");
    end

    // R4: one byte off at each symbol position, then a changed filter
    for (int p = 0; p < 8; p++) begin
      build(p + 600, 8'h41, 8'h53);
      mbuf[18+p] = mbuf[18+p] ^ 8'h01;
      send_msg(30, "R4 symbol mismatch");
    end
    sym_cfg = 64'h5857_2020_2020_2020;
    build(700, 8'h41, 8'h42); send_msg(30, "R4 new symbol accepted");
    sym_cfg = 64'h4142_4344_2020_2020;
    build(701, 8'h41, 8'h42); mbuf[18] = 8'h58; mbuf[19] = 8'h57;
    send_msg(30, "R4 old filter rejects");

    // R2 R7: lengths 0..40 with zero-length messages in between
    for (int l = 0; l <= 40; l++) begin
      send_msg(0, "R2 empty message");
      build(l + 800, 8'h41, 8'h42);
      send_msg(l, "R7 length sweep");
    end

    // R9: stalled consumer
    cmd_ready = 1'b0;
    build(900, 8'h41, 8'h53);
    send_msg(30, "R8 stall message");
    in_valid = 1'b1;
    in_data  = 8'h00;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(in_ready == 0, "R9 in_ready low while held", 161'(in_ready), 0);
      chk(cmd_valid == 1, "R9 cmd held", 161'(cmd_valid), 1);
      chk(cmd_ts == 32'h1000_0000 + 32'd900 * 32'h0001_0203, "R9 fields stable",
          161'(cmd_ts), 161'(32'h1000_0000 + 32'd900 * 32'h0001_0203));
      @(posedge clk);
      #1;
    end
    in_valid  = 1'b0;
    cmd_ready = 1'b1;
    @(posedge clk);
    #1;
    build(901, 8'h41, 8'h42); send_msg(30, "R9 aligned after stall");

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && got == pushed, "R10 one command per kept message",
        161'(got), 161'(pushed));
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule